// File: doc/BRIEF.md
# Fabric Register Bridge

This block sits between the system bus and logic placed inside an embedded programmable fabric. A processor reaches it as an AXI4-Lite slave with a 64-bit data path. It exposes a control register, a status register and six 64-bit data registers.

Software fills the data registers in any order. It then sets the commit bit in the control register. On that write the six data registers are copied, in a single clock edge, into a 384-bit latch that drives the fabric. A one-cycle commit strobe goes with the copy, so the fabric always sees one complete and consistent word.

The fabric reports three flags: configured, busy and result valid. These flags are sampled into the status register, which software polls.

Top module: `fabric_reg_bridge`

## Requirements
- R1: After rst_ni is released, fab_word_o, fab_ctrl_o, fab_commit_o, s_bvalid_o and s_rvalid_o are all zero, and s_arready_o is 1.
- R2: A write is accepted in the cycle where s_awvalid_i and s_wvalid_i are both high and no write response is pending. s_bvalid_o rises on the next cycle and stays high with a stable s_bresp_o until s_bready_i is seen. While it is high, no further write is accepted.
- R3: A read is accepted when s_arvalid_i is high and no read response is pending. s_rvalid_o rises on the next cycle and holds s_rdata_o and s_rresp_o stable until s_rready_i is seen. s_arready_o is low while s_rvalid_o is high.
- R4: Data register k (k = 0..5) sits at byte offset 0x10 + 8k and reads back what was written. Only the bytes whose s_wstrb_i bit is set are updated.
- R5: A write to offset 0x00 with s_wstrb_i[0] = 1 and s_wdata_i[0] = 1 copies data register k into fab_word_o[64k+63:64k] for all k. The copy and a one-cycle fab_commit_o pulse appear together in the cycle after acceptance, which is the cycle s_bvalid_o rises. If bit 0 is written as 0, or its strobe is clear, nothing is copied.
- R6: fab_word_o changes only on a commit; writes to the data registers alone leave it unchanged.
- R7: Control bits 63:1 are stored with byte enables and driven on fab_ctrl_o. Bit 0 always reads 0 and is 0 on fab_ctrl_o.
- R8: Offset 0x08 reads {61'b0, fab_result_valid_i, fab_busy_i, fab_configured_i}, each input sampled through one register.
- R9: A write to offset 0x08 returns OKAY (2'b00) and changes nothing.
- R10: An access to any other offset, or to an address not aligned to 8 bytes, returns SLVERR (2'b10). It changes no register, and a read returns data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | 12 | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 64 | Write data |
| s_wstrb_i | input | 8 | Write byte enables |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | 12 | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 64 | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read response valid |
| s_rready_i | input | 1 | Read response ready |
| fab_ctrl_o | output | 64 | Control word to fabric, bit 0 zero |
| fab_word_o | output | 384 | Committed data word to fabric |
| fab_commit_o | output | 1 | One-cycle strobe with each new word |
| fab_configured_i | input | 1 | Fabric configured flag |
| fab_busy_i | input | 1 | Fabric busy flag |
| fab_result_valid_i | input | 1 | Fabric result valid flag |

## Verification
The assertions assume the master keeps address and data valid together until acceptance, as AXI4-Lite requires. They also assume the master never has more than one read and one write outstanding, so a commit strobe can never follow another in the next cycle. The bench's write and read tasks raise address and data valid in the same cycle and hold them until accepted. They then wait for the response before issuing anything else. The backpressure scenarios stall the response channels while a new request is already pending. The fabric status inputs change only between accesses.

// File: rtl/fabric_bridge_pkg.sv
package fabric_bridge_pkg;
  typedef enum logic [1:0] {SEL_CTRL, SEL_STAT, SEL_DATA, SEL_NONE} reg_sel_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  localparam int unsigned SLOT_CTRL  = 0;
  localparam int unsigned SLOT_STAT  = 1;
  localparam int unsigned SLOT_DATA0 = 2;
  localparam int unsigned STAT_W     = 3;
  localparam int unsigned COMMIT_BIT = 0;
endpackage

// File: rtl/fabric_bridge_dec.sv
module fabric_bridge_dec
  import fabric_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned N_DATA = 6,
  localparam int unsigned IDX_W = (N_DATA > 1) ? $clog2(N_DATA) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned SW = ADDR_W - 3;

  logic [SW-1:0] slot;
  logic [SW-1:0] rel;
  assign slot = addr_i[ADDR_W-1:3];
  assign rel  = slot - SW'(SLOT_DATA0);

  always_comb begin
    sel_o = SEL_NONE;
    idx_o = '0;
    if (addr_i[2:0] == 3'b000) begin
      if (slot == SW'(SLOT_CTRL))      sel_o = SEL_CTRL;
      else if (slot == SW'(SLOT_STAT)) sel_o = SEL_STAT;
      else if (slot >= SW'(SLOT_DATA0) && slot < SW'(SLOT_DATA0 + N_DATA)) begin
        sel_o = SEL_DATA;
        idx_o = IDX_W'(rel);
      end
    end
  end
endmodule

// File: rtl/fabric_bridge_axi_if.sv
module fabric_bridge_axi_if
  import fabric_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [DATA_W-1:0] s_wdata_i,
  input  logic [STRB_W-1:0] s_wstrb_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [ADDR_W-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [DATA_W-1:0] s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [STRB_W-1:0] wr_strb_o,
  input  logic              wr_ok_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_ok_i
);
  logic              bvalid_q, rvalid_q;
  logic [1:0]        bresp_q, rresp_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_fire, rd_fire;

  // address and data taken together; one response outstanding per channel
  assign wr_fire     = s_awvalid_i && s_wvalid_i && !bvalid_q;
  assign rd_fire     = s_arvalid_i && !rvalid_q;
  assign s_awready_o = wr_fire;
  assign s_wready_o  = wr_fire;
  assign s_arready_o = !rvalid_q;

  assign wr_en_o   = wr_fire;
  assign wr_addr_o = s_awaddr_i;
  assign wr_data_o = s_wdata_i;
  assign wr_strb_o = s_wstrb_i;
  assign rd_addr_o = s_araddr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bvalid_q <= 1'b0;
      bresp_q  <= RESP_OKAY;
    end else if (wr_fire) begin
      bvalid_q <= 1'b1;
      bresp_q  <= wr_ok_i ? RESP_OKAY : RESP_SLVERR;
    end else if (s_bready_i) begin
      bvalid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rresp_q  <= RESP_OKAY;
      rdata_q  <= '0;
    end else if (rd_fire) begin
      rvalid_q <= 1'b1;
      rresp_q  <= rd_ok_i ? RESP_OKAY : RESP_SLVERR;
      rdata_q  <= rd_ok_i ? rd_data_i : '0;
    end else if (s_rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  assign s_bvalid_o = bvalid_q;
  assign s_bresp_o  = bresp_q;
  assign s_rvalid_o = rvalid_q;
  assign s_rresp_o  = rresp_q;
  assign s_rdata_o  = rdata_q;

  assert_bvalid_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o && !s_bready_i |=> s_bvalid_o && $stable(s_bresp_o));

  assert_rvalid_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o && !s_rready_i |=> s_rvalid_o && $stable(s_rdata_o) && $stable(s_rresp_o));

  assert_bresp_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o |-> (s_bresp_o == RESP_OKAY || s_bresp_o == RESP_SLVERR));

  assert_err_rdata_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o && s_rresp_o == RESP_SLVERR |-> s_rdata_o == '0);
endmodule

// File: rtl/fabric_bridge_regs.sv
module fabric_bridge_regs
  import fabric_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned N_DATA = 6,
  localparam int unsigned STRB_W = DATA_W / 8,
  localparam int unsigned WORD_W = N_DATA * DATA_W,
  localparam int unsigned IDX_W  = (N_DATA > 1) ? $clog2(N_DATA) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [STRB_W-1:0] wr_strb_i,
  input  reg_sel_e          rd_sel_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [STAT_W-1:0] stat_i,
  output logic [DATA_W-1:0] fab_ctrl_o,
  output logic [WORD_W-1:0] fab_word_o,
  output logic              fab_commit_o
);
  localparam logic [DATA_W-1:0] CTRL_MASK = ~(DATA_W'(1) << COMMIT_BIT);

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] new_v,
                                              input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int b = 0; b < STRB_W; b++)
      if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] data_q [N_DATA];
  logic [WORD_W-1:0] data_flat;
  logic [WORD_W-1:0] word_q;
  logic              commit_q;
  logic [STAT_W-1:0] stat_q;
  logic              do_commit;

  assign do_commit = wr_en_i && wr_sel_i == SEL_CTRL
                     && wr_strb_i[COMMIT_BIT/8] && wr_data_i[COMMIT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ctrl_q <= '0;
    else if (wr_en_i && wr_sel_i == SEL_CTRL) ctrl_q <= merge(ctrl_q, wr_data_i, wr_strb_i) & CTRL_MASK;
  end

  for (genvar g = 0; g < N_DATA; g++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_q[g] <= '0;
      else if (wr_en_i && wr_sel_i == SEL_DATA && wr_idx_i == IDX_W'(g))
        data_q[g] <= merge(data_q[g], wr_data_i, wr_strb_i);
    end
    assign data_flat[g*DATA_W +: DATA_W] = data_q[g];
  end

  // whole word moves on one edge; commit bit is never stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q   <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= do_commit;
      if (do_commit) word_q <= data_flat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_i;
  end

  always_comb begin
    unique case (rd_sel_i)
      SEL_CTRL: rd_data_o = ctrl_q;
      SEL_STAT: rd_data_o = DATA_W'(stat_q);
      SEL_DATA: rd_data_o = data_q[rd_idx_i];
      default:  rd_data_o = '0;
    endcase
  end

  assign fab_ctrl_o   = ctrl_q;
  assign fab_word_o   = word_q;
  assign fab_commit_o = commit_q;

  assert_commit_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fab_commit_o |=> !fab_commit_o);

  assert_word_only_on_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fab_commit_o |-> $stable(fab_word_o));

  assert_ctrl_lsb_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == SEL_CTRL |=> !fab_ctrl_o[COMMIT_BIT]);
endmodule

// File: rtl/fabric_reg_bridge.sv
module fabric_reg_bridge
  import fabric_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned N_DATA = 6,
  localparam int unsigned STRB_W = DATA_W / 8,
  localparam int unsigned WORD_W = N_DATA * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [DATA_W-1:0] s_wdata_i,
  input  logic [STRB_W-1:0] s_wstrb_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [ADDR_W-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [DATA_W-1:0] s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  output logic [DATA_W-1:0] fab_ctrl_o,
  output logic [WORD_W-1:0] fab_word_o,
  output logic              fab_commit_o,
  input  logic              fab_configured_i,
  input  logic              fab_busy_i,
  input  logic              fab_result_valid_i
);
  localparam int unsigned IDX_W = (N_DATA > 1) ? $clog2(N_DATA) : 1;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [STRB_W-1:0] wr_strb;
  reg_sel_e          wr_sel, rd_sel;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  fabric_bridge_axi_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_axi (
    .clk_i, .rst_ni,
    .s_awaddr_i, .s_awvalid_i, .s_awready_o,
    .s_wdata_i, .s_wstrb_i, .s_wvalid_i, .s_wready_o,
    .s_bresp_o, .s_bvalid_o, .s_bready_i,
    .s_araddr_i, .s_arvalid_i, .s_arready_o,
    .s_rdata_o, .s_rresp_o, .s_rvalid_o, .s_rready_i,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_strb_o(wr_strb),
    .wr_ok_i(wr_sel != SEL_NONE),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .rd_ok_i(rd_sel != SEL_NONE)
  );

  fabric_bridge_dec #(.ADDR_W(ADDR_W), .N_DATA(N_DATA)) u_wdec (
    .addr_i(wr_addr), .sel_o(wr_sel), .idx_o(wr_idx)
  );

  fabric_bridge_dec #(.ADDR_W(ADDR_W), .N_DATA(N_DATA)) u_rdec (
    .addr_i(rd_addr), .sel_o(rd_sel), .idx_o(rd_idx)
  );

  fabric_bridge_regs #(.DATA_W(DATA_W), .N_DATA(N_DATA)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .rd_sel_i(rd_sel), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .stat_i({fab_result_valid_i, fab_busy_i, fab_configured_i}),
    .fab_ctrl_o, .fab_word_o, .fab_commit_o
  );
endmodule

// File: tb/sim_fabric_reg_bridge.sv
module sim_fabric_reg_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [11:0]  awaddr = '0, araddr = '0;
  logic         awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [63:0]  wdata = '0;
  logic [7:0]   wstrb = '0;
  logic         awready, wready, bvalid, arready, rvalid, commit;
  logic [1:0]   bresp, rresp;
  logic [63:0]  rdata, fctrl;
  logic [383:0] fword;
  logic         f_cfg = 0, f_busy = 0, f_rv = 0;

  fabric_reg_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready),
    .fab_ctrl_o(fctrl), .fab_word_o(fword), .fab_commit_o(commit),
    .fab_configured_i(f_cfg), .fab_busy_i(f_busy), .fab_result_valid_i(f_rv)
  );

  int n_chk = 0, n_fail = 0;
  logic [63:0] exp_data [6];
  logic [383:0] exp_word = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req);
    for (int k = 0; k < 6; k++)
      chk(fword[k*64 +: 64] === exp_word[k*64 +: 64], req, fword[k*64 +: 64], exp_word[k*64 +: 64]);
  endtask

  task automatic axi_write(input logic [11:0] a, input logic [63:0] d, input logic [7:0] s,
                           output logic [1:0] resp, output logic cm);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1; bready = 1;
    while (!awready) @(negedge clk);
    @(posedge clk); #1;
    awvalid = 0; wvalid = 0;
    @(negedge clk);
    while (!bvalid) @(negedge clk);
    resp = bresp; cm = commit;
    @(posedge clk); #1;
    bready = 0;
  endtask

  task automatic axi_read(input logic [11:0] a, output logic [63:0] d, output logic [1:0] resp);
    @(negedge clk);
    araddr = a; arvalid = 1; rready = 1;
    while (!arready) @(negedge clk);
    @(posedge clk); #1;
    arvalid = 0;
    @(negedge clk);
    while (!rvalid) @(negedge clk);
    d = rdata; resp = rresp;
    @(posedge clk); #1;
    rready = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(fword === '0, "R1 word", fword[63:0], 64'h0);
    chk(fctrl === '0, "R1 ctrl", fctrl, 64'h0);
    chk(commit === 1'b0 && bvalid === 1'b0 && rvalid === 1'b0, "R1 valids", {bvalid, rvalid, commit}, 64'h0);
    chk(arready === 1'b1, "R1 arready", arready, 64'h1);
  endtask

  task automatic t_data_rw;
    logic [1:0] r; logic cm; logic [63:0] d;
    for (int k = 0; k < 6; k++) begin
      exp_data[k] = 64'h1111_0000_0000_0000 * (k + 1) + 64'h0000_0000_A5A5_0000 + k;
      axi_write(12'h010 + 12'(8 * k), exp_data[k], 8'hFF, r, cm);
      chk(r === 2'b00, "R4 write resp", r, 0);
    end
    for (int k = 5; k >= 0; k--) begin
      axi_read(12'h010 + 12'(8 * k), d, r);
      chk(d === exp_data[k] && r === 2'b00, "R4 readback", d, exp_data[k]);
    end
  endtask

  task automatic t_strobe;
    logic [1:0] r; logic cm; logic [63:0] d;
    axi_write(12'h020, 64'hFFFF_FFFF_FFFF_FFFF, 8'b1010_0101, r, cm);
    exp_data[2] = {8'hFF, exp_data[2][55:48], 8'hFF, exp_data[2][39:32],
                   exp_data[2][31:24], 8'hFF, exp_data[2][15:8], 8'hFF};
    axi_read(12'h020, d, r);
    chk(d === exp_data[2], "R4 strobe merge", d, exp_data[2]);
  endtask

  task automatic t_no_commit;
    @(negedge clk);
    chk_word("R6 no commit yet");
  endtask

  task automatic t_commit;
    logic [1:0] r; logic cm;
    for (int k = 0; k < 6; k++) exp_word[k*64 +: 64] = exp_data[k];
    axi_write(12'h000, 64'h1, 8'h01, r, cm);
    chk(cm === 1'b1, "R5 strobe with response", cm, 1);
    chk_word("R5 commit copy");
    @(negedge clk);
    chk(commit === 1'b0, "R5 pulse one cycle", commit, 0);
    // bit 0 set but its strobe clear
    exp_data[0] = 64'hDEAD_0000_BEEF_0000;
    axi_write(12'h010, exp_data[0], 8'hFF, r, cm);
    axi_write(12'h000, 64'h1, 8'hFE, r, cm);
    chk(cm === 1'b0, "R5 masked commit", cm, 0);
    @(negedge clk);
    chk_word("R6 word held after data write");
    axi_write(12'h000, 64'h0, 8'hFF, r, cm);
    chk(cm === 1'b0, "R5 zero bit no commit", cm, 0);
  endtask

  task automatic t_ctrl;
    logic [1:0] r; logic cm; logic [63:0] d;
    axi_write(12'h000, 64'hCAFE_F00D_1234_5679, 8'hFF, r, cm);
    chk(cm === 1'b1, "R5 commit with ctrl data", cm, 1);
    exp_word[63:0] = exp_data[0];
    chk_word("R5 second commit");
    axi_read(12'h000, d, r);
    chk(d === 64'hCAFE_F00D_1234_5678, "R7 ctrl readback", d, 64'hCAFE_F00D_1234_5678);
    chk(fctrl === 64'hCAFE_F00D_1234_5678, "R7 ctrl output", fctrl, 64'hCAFE_F00D_1234_5678);
    axi_write(12'h000, 64'h0, 8'b1000_0000, r, cm);
    axi_read(12'h000, d, r);
    chk(d === 64'h00FE_F00D_1234_5678, "R7 ctrl strobe", d, 64'h00FE_F00D_1234_5678);
  endtask

  task automatic t_status;
    logic [1:0] r; logic cm; logic [63:0] d;
    @(negedge clk); f_cfg = 1; f_busy = 0; f_rv = 1;
    axi_read(12'h008, d, r);
    chk(d === 64'h5 && r === 2'b00, "R8 status 101", d, 64'h5);
    @(negedge clk); f_cfg = 0; f_busy = 1; f_rv = 0;
    axi_read(12'h008, d, r);
    chk(d === 64'h2, "R8 status 010", d, 64'h2);
    axi_write(12'h008, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, r, cm);
    chk(r === 2'b00, "R9 status write okay", r, 0);
    axi_read(12'h008, d, r);
    chk(d === 64'h2, "R9 status unchanged", d, 64'h2);
  endtask

  task automatic t_unmapped;
    logic [1:0] r; logic cm; logic [63:0] d;
    axi_write(12'h040, 64'h1234, 8'hFF, r, cm);
    chk(r === 2'b10, "R10 write unmapped", r, 2);
    axi_read(12'h040, d, r);
    chk(r === 2'b10 && d === '0, "R10 read unmapped", {r, d[61:0]}, 64'h8000_0000_0000_0000);
    axi_write(12'h014, 64'h0BAD, 8'hFF, r, cm);
    chk(r === 2'b10, "R10 misaligned write", r, 2);
    axi_read(12'h018, d, r);
    chk(d === exp_data[1], "R10 no side effect", d, exp_data[1]);
    axi_read(12'h00C, d, r);
    chk(r === 2'b10 && d === '0, "R10 misaligned read", d, 0);
  endtask

  task automatic t_backpressure;
    logic [1:0] r; logic [63:0] d;
    @(negedge clk);
    awaddr = 12'h038; wdata = 64'h5555; wstrb = 8'hFF; awvalid = 1; wvalid = 1; bready = 0;
    @(posedge clk); #1;
    awaddr = 12'h030; wdata = 64'h4444;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(bvalid === 1'b1 && awready === 1'b0, "R2 response held", {bvalid, awready}, 64'h2);
    end
    bready = 1;
    @(negedge clk);
    while (!awready) @(negedge clk);
    @(posedge clk); #1;
    awvalid = 0; wvalid = 0;
    @(negedge clk);
    chk(bvalid === 1'b1 && bresp === 2'b00, "R2 second write", bvalid, 1);
    @(posedge clk); #1; bready = 0;
    exp_data[5] = 64'h5555; exp_data[4] = 64'h4444;
    axi_read(12'h038, d, r);
    chk(d === exp_data[5], "R2 first write landed", d, exp_data[5]);
    @(negedge clk);
    araddr = 12'h030; arvalid = 1; rready = 0;
    @(posedge clk); #1; arvalid = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rvalid === 1'b1 && arready === 1'b0 && rdata === exp_data[4], "R3 read held", rdata, exp_data[4]);
    end
    rready = 1;
    @(posedge clk); #1; rready = 0;
    @(negedge clk);
    chk(rvalid === 1'b0, "R3 read released", rvalid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_data_rw();
    t_strobe();
    t_no_commit();
    t_commit();
    t_ctrl();
    t_status();
    t_unmapped();
    t_backpressure();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule